// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial line into characters. A prescaler outside the block supplies a one-cycle enable, `tick16`, at sixteen times the bit rate. The block finds the falling edge of a start bit and checks that the line is still low at the middle of that bit. It then samples each following bit at its midpoint. A character is 7, 8 or 9 bits long, sent least or most significant bit first. An optional odd or even parity bit and one or two stop bits follow it. The input pin can be inverted as a whole. Data-logic inversion flips only the character and parity bits. A majority-free glitch filter can be placed in front of the receiver. It accepts a new level only after three equal samples.

A finished character goes into a single holding register, and a one-cycle interrupt pulse marks the transfer. The parity and framing flags are written at that same transfer. An overrun is raised if the holding register is still unread when the next frame reaches the bit just before its final stop bit. A summary flag reports any of the three errors. A host read clears the holding register and all flags. An optional request-to-send output tells the far end to pause while the holding register is full or reception is off.

The receive state machine has six states: IDLE, START, DATA, PARITY, STOP1 and STOP2. It has these transitions:
- IDLE to START on a falling edge of the line.
- START back to IDLE if the line is high at mid-start (a glitch).
- START to DATA otherwise.
- DATA to PARITY or to STOP1 after the last character bit.
- PARITY to STOP1.
- STOP1 to STOP2 when two stop bits are set, or STOP1 to IDLE otherwise.
- STOP2 to IDLE.
- Every state returns to IDLE when reception is disabled.

Top module: `uart_rx_core`

## Requirements
- R1: After reset `rx_full`, `rx_irq` and all error flags are low. With `rx_en` high, `rts_out` is low.
- R2: With `rx_en` high, a frame is received and its character appears right-aligned in `rx_data`, with unused upper bits zero. `cfg_len` 0 selects 7 bits, 1 selects 8 bits, 2 selects 9 bits and 3 selects 8 bits. `rx_full` is set and `rx_irq` pulses for exactly one cycle per transfer.
- R3: With `cfg_msb_first` high, the first data bit received is the character's most significant bit. With it low, the first bit is bit 0.
- R4: With `cfg_par_en` high, `err_parity` is set at the transfer when the count of ones over the character and parity bits is odd while `cfg_par_odd` is 0, or even while `cfg_par_odd` is 1. It changes only at a transfer.
- R5: `err_frame` is set at the transfer when any configured stop bit (1, or 2 with `cfg_two_stop`) is sampled low. It changes only at a transfer.
- R6: `err_overrun` is set when `rx_full` is still high at the midpoint of the bit just before the final stop bit of the next frame.
- R7: `err_sum` is high whenever any of `err_overrun`, `err_frame` or `err_parity` is high.
- R8: A one-cycle `rd_strobe` clears `rx_full` and all error flags, unless a transfer occurs in the same cycle.
- R9: A start edge whose line is back high at the start bit's midpoint is dropped, and no character is transferred.
- R10: `cfg_data_inv` inverts the sampled character and parity bits but not the start and stop bits.
- R11: `cfg_pin_inv` inverts the whole incoming line, idle level included.
- R12: With `cfg_filt_en` high, a pulse shorter than three ticks does not reach the receiver. With it low, each bit is taken from the line level at tick 8 of its 16 ticks, so such a pulse there alters the bit.
- R13: With `cfg_rts_en` high, `rts_out` is high while `rx_full` is high or `rx_en` is low, and low otherwise. With `cfg_rts_en` low, `rts_out` is low.
- R14: While `rx_en` is low no frame is received and any frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit |
| rx_pin | input | 1 | Serial input pin |
| rx_en | input | 1 | Reception enable |
| cfg_len | input | 2 | Character length code (0:7, 1:8, 2:9, 3:8) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | Two stop bits expected |
| cfg_msb_first | input | 1 | Most significant bit received first |
| cfg_data_inv | input | 1 | Invert character and parity bits |
| cfg_pin_inv | input | 1 | Invert the whole input line |
| cfg_filt_en | input | 1 | Enable three-sample input filter |
| cfg_rts_en | input | 1 | Enable request-to-send output |
| rd_strobe | input | 1 | Host read of the holding register |
| rx_data | output | 9 | Received character |
| rx_full | output | 1 | Holding register holds an unread character |
| rx_irq | output | 1 | One-cycle pulse at each transfer |
| err_overrun | output | 1 | Overrun flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | Any error flag set |
| rts_out | output | 1 | Request-to-send, high means pause |

## Verification
The bench builds the block with its defaults: sixteen ticks per bit and a three-sample filter. At these values the midpoint is a fixed tick. A two-tick pulse at that tick separates the filtered path from the unfiltered one. Character lengths of 7, 8 and 9 bits are all reachable through `cfg_len`. Random frames mix every length, order, parity, stop count and inversion setting, with injected parity and stop faults. Directed frames cover overrun, start glitches, disabled reception and flow control.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 9;
    localparam int CNT_W  = $clog2(CHAR_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef enum logic [1:0] {
        LEN_7   = 2'd0,
        LEN_8   = 2'd1,
        LEN_9   = 2'd2,
        LEN_RSV = 2'd3
    } char_len_e;

    // Number of character bits for a length code
    function automatic logic [CNT_W-1:0] char_bits(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        unique case (char_len_e'(code))
            LEN_7:   n = CNT_W'(7);
            LEN_9:   n = CNT_W'(9);
            default: n = CNT_W'(8);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rx_line_filter.sv
module rx_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    input  logic pin_inv,
    input  logic filt_en,
    output logic line
);

    localparam int HW = (FILT_LEN > 1) ? FILT_LEN - 1 : 1;

    logic          raw;
    logic [HW-1:0] hist_q;
    logic          filt_q;
    logic          all_hi;
    logic          all_lo;

    assign raw    = pin ^ pin_inv;
    assign all_hi = raw & (&hist_q);
    assign all_lo = ~raw & ~(|hist_q);

    generate
        if (HW == 1) begin : g_short
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    hist_q <= '1;
                else if (tick) hist_q <= raw;
            end
        end else begin : g_long
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    hist_q <= '1;
                else if (tick) hist_q <= {hist_q[HW-2:0], raw};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
        end else if (tick) begin
            if (all_hi)      filt_q <= 1'b1;
            else if (all_lo) filt_q <= 1'b0;
        end
    end

    // Unfiltered path: the level registered at the previous tick
    assign line = filt_en ? filt_q : hist_q[0];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              rx_en,
    input  logic [1:0]        cfg_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              msb_first,
    input  logic              data_inv,
    output logic              ovr_chk,
    output logic              done,
    output logic [CHAR_W-1:0] char_data,
    output logic              frame_err,
    output logic              parity_err
);

    localparam int CW   = (OSR > 2) ? $clog2(OSR) : 1;
    localparam int HALF = OSR / 2;

    rx_state_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CHAR_W-1:0] shreg_q;
    logic              par_acc_q;
    logic              stop_bad_q;
    logic              line_prev_q;

    logic [CNT_W-1:0]  nbits;
    logic [CNT_W-1:0]  pos;
    logic              smp;
    logic              last_bit;
    logic              dbit;
    logic              start_edge;
    logic              samp_now;

    assign nbits      = char_bits(cfg_len);
    assign last_bit   = (idx_q == nbits - CNT_W'(1));
    assign pos        = msb_first ? (nbits - CNT_W'(1) - idx_q) : idx_q;
    assign dbit       = line ^ data_inv;
    assign start_edge = ~line & line_prev_q;
    assign smp        = (state_q == ST_START) ? (cnt_q == CW'(HALF - 1))
                                              : (cnt_q == CW'(OSR - 1));
    assign samp_now   = rx_en & tick & smp & (state_q != ST_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!rx_en) begin
            state_d = ST_IDLE;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE:   if (start_edge) state_d = ST_START;
                ST_START:  if (smp) state_d = line ? ST_IDLE : ST_DATA;
                ST_DATA:   if (smp && last_bit) state_d = par_en ? ST_PARITY : ST_STOP1;
                ST_PARITY: if (smp) state_d = ST_STOP1;
                ST_STOP1:  if (smp) state_d = two_stop ? ST_STOP2 : ST_IDLE;
                ST_STOP2:  if (smp) state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit timing and shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            idx_q       <= '0;
            shreg_q     <= '0;
            par_acc_q   <= 1'b0;
            stop_bad_q  <= 1'b0;
            line_prev_q <= 1'b1;
        end else begin
            if (tick) line_prev_q <= line;
            if (rx_en && tick) begin
                if (state_q == ST_IDLE) begin
                    if (start_edge) begin
                        cnt_q      <= CW'(1);
                        idx_q      <= '0;
                        shreg_q    <= '0;
                        par_acc_q  <= 1'b0;
                        stop_bad_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= smp ? '0 : cnt_q + CW'(1);
                    if (smp && state_q == ST_DATA) begin
                        shreg_q[pos] <= dbit;
                        par_acc_q    <= par_acc_q ^ dbit;
                        idx_q        <= idx_q + CNT_W'(1);
                    end
                    if (smp && state_q == ST_PARITY) par_acc_q  <= par_acc_q ^ dbit;
                    if (smp && state_q == ST_STOP1)  stop_bad_q <= stop_bad_q | ~line;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        done       = samp_now & (((state_q == ST_STOP1) & ~two_stop) | (state_q == ST_STOP2));
        ovr_chk    = samp_now & (((state_q == ST_DATA) & last_bit & ~par_en & ~two_stop)
                               | ((state_q == ST_PARITY) & ~two_stop)
                               | ((state_q == ST_STOP1) & two_stop));
        char_data  = shreg_q;
        frame_err  = stop_bad_q | ~line;
        parity_err = par_en & (par_acc_q != par_odd);
    end

endmodule

// File: rtl/rx_hold_buffer.sv
module rx_hold_buffer
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              ovr_chk,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              frame_err,
    input  logic              parity_err,
    input  logic              rd,
    input  logic              rx_en,
    input  logic              rts_en,
    output logic [CHAR_W-1:0] data,
    output logic              full,
    output logic              irq,
    output logic              ov,
    output logic              fe,
    output logic              pe,
    output logic              sum,
    output logic              rts
);

    logic [CHAR_W-1:0] data_q;
    logic full_q, irq_q, ov_q, fe_q, pe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
            irq_q  <= 1'b0;
            ov_q   <= 1'b0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
        end else begin
            irq_q <= done;
            if (done) begin
                data_q <= char_data;
                full_q <= 1'b1;
                fe_q   <= frame_err;
                pe_q   <= parity_err;
                if (rd) ov_q <= 1'b0;
            end else if (rd) begin
                full_q <= 1'b0;
                fe_q   <= 1'b0;
                pe_q   <= 1'b0;
                ov_q   <= 1'b0;
            end else if (ovr_chk && full_q) begin
                ov_q <= 1'b1;
            end
        end
    end

    always_comb begin
        data = data_q;
        full = full_q;
        irq  = irq_q;
        ov   = ov_q;
        fe   = fe_q;
        pe   = pe_q;
        sum  = ov_q | fe_q | pe_q;
        rts  = rts_en & (full_q | ~rx_en);
    end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_pin,
    input  logic              rx_en,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_msb_first,
    input  logic              cfg_data_inv,
    input  logic              cfg_pin_inv,
    input  logic              cfg_filt_en,
    input  logic              cfg_rts_en,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              err_overrun,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_sum,
    output logic              rts_out
);

    logic              line;
    logic              ovr_chk;
    logic              done;
    logic [CHAR_W-1:0] char_data;
    logic              frame_err;
    logic              parity_err;

    rx_line_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .pin     (rx_pin),
        .pin_inv (cfg_pin_inv),
        .filt_en (cfg_filt_en),
        .line    (line)
    );

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .line       (line),
        .rx_en      (rx_en),
        .cfg_len    (cfg_len),
        .par_en     (cfg_par_en),
        .par_odd    (cfg_par_odd),
        .two_stop   (cfg_two_stop),
        .msb_first  (cfg_msb_first),
        .data_inv   (cfg_data_inv),
        .ovr_chk    (ovr_chk),
        .done       (done),
        .char_data  (char_data),
        .frame_err  (frame_err),
        .parity_err (parity_err)
    );

    rx_hold_buffer u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .ovr_chk    (ovr_chk),
        .char_data  (char_data),
        .frame_err  (frame_err),
        .parity_err (parity_err),
        .rd         (rd_strobe),
        .rx_en      (rx_en),
        .rts_en     (cfg_rts_en),
        .data       (rx_data),
        .full       (rx_full),
        .irq        (rx_irq),
        .ov         (err_overrun),
        .fe         (err_frame),
        .pe         (err_parity),
        .sum        (err_sum),
        .rts        (rts_out)
    );

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic rd_strobe,
    input logic cfg_rts_en,
    input logic rx_irq,
    input logic rx_full,
    input logic err_overrun,
    input logic err_frame,
    input logic err_parity,
    input logic err_sum,
    input logic rts_out
);

    assert_irq_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    assert_irq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    assert_parity_at_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_parity) |-> rx_irq);

    assert_frame_at_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_frame) |-> rx_irq);

    assert_overrun_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(rx_full));

    assert_sum_with_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_sum |-> rx_full);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (rx_irq || (!rx_full && !err_sum)));

    assert_rts_on_xfer_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rts_en && rx_irq) |-> rts_out);

    assert_disabled_quiet_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_en) |-> !rx_irq);

endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .rd_strobe   (rd_strobe),
    .cfg_rts_en  (cfg_rts_en),
    .rx_irq      (rx_irq),
    .rx_full     (rx_full),
    .err_overrun (err_overrun),
    .err_frame   (err_frame),
    .err_parity  (err_parity),
    .err_sum     (err_sum),
    .rts_out     (rts_out)
);

// File: tb/uart_rx_core_bench.sv
`timescale 1ns/1ps
module uart_rx_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_pin = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] cfg_len = 2'd1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_data_inv = 1'b0;
    logic       cfg_pin_inv = 1'b0;
    logic       cfg_filt_en = 1'b0;
    logic       cfg_rts_en = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, rx_irq, err_overrun, err_frame, err_parity, err_sum, rts_out;

    int vectors = 0;
    int miscompares = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_rx_core u_uart_rx_core (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_pin(rx_pin), .rx_en(rx_en),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
        .cfg_data_inv(cfg_data_inv), .cfg_pin_inv(cfg_pin_inv),
        .cfg_filt_en(cfg_filt_en), .cfg_rts_en(cfg_rts_en), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
        .err_overrun(err_overrun), .err_frame(err_frame), .err_parity(err_parity),
        .err_sum(err_sum), .rts_out(rts_out)
    );

    always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

    function automatic int nbits(input logic [1:0] code);
        return (code == 2'd0) ? 7 : (code == 2'd2) ? 9 : 8;
    endfunction

    function automatic logic [8:0] len_mask(input logic [1:0] code);
        return 9'((1 << nbits(code)) - 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One oversampling tick carrying logical line level v
    task automatic tick_once(input logic v);
        @(negedge clk);
        rx_pin = v ^ cfg_pin_inv;
        tick16 = 1'b1;
        @(negedge clk);
        tick16 = 1'b0;
    endtask

    task automatic send_bit(input logic v, input bit spike);
        for (int t = 0; t < 16; t++)
            tick_once((spike && (t == 6 || t == 7)) ? ~v : v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick_once(1'b1);
    endtask

    task automatic send_frame(input logic [8:0] d, input bit bad_par,
                              input bit bad_stop, input bit spike0);
        int  n;
        logic ones, b, pb;
        n = nbits(cfg_len);
        ones = 1'b0;
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            b = cfg_msb_first ? d[n-1-i] : d[i];
            ones ^= b;
            send_bit(b ^ cfg_data_inv, spike0 && (i == 0));
        end
        if (cfg_par_en) begin
            pb = cfg_par_odd ? ~ones : ones;
            if (bad_par) pb = ~pb;
            send_bit(pb ^ cfg_data_inv, 1'b0);
        end
        if (cfg_two_stop) send_bit(1'b1, 1'b0);
        send_bit(bad_stop ? 1'b0 : 1'b1, 1'b0);
        idle(24);
    endtask

    task automatic read_buf();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_char(input string tag, input logic [8:0] exp_d,
                              input bit fe, input bit pe, input bit ov, input int exp_irq);
        chk({tag, " data"}, rx_data, exp_d);
        chk({tag, " full"}, rx_full, 1);
        chk({tag, " frame"}, err_frame, fe);
        chk({tag, " parity"}, err_parity, pe);
        chk({tag, " overrun"}, err_overrun, ov);
        chk({tag, " sum R7"}, err_sum, fe | pe | ov);
        chk({tag, " irq count"}, irq_cnt, exp_irq);
    endtask

    initial begin
        int exp_irq;
        logic [8:0] d;
        bit bp, bs;
        void'($urandom(32'h1F2E3D4C));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 full", rx_full, 0);
        chk("R1 irq", rx_irq, 0);
        chk("R1 sum", err_sum, 0);
        chk("R1 rts", rts_out, 0);
        idle(8);
        exp_irq = 0;

        // R2 8-bit LSB-first, R13 rts while full
        send_frame(9'h0A5, 0, 0, 0);
        exp_irq++;
        check_char("R2 8bit", 9'h0A5, 0, 0, 0, exp_irq);
        chk("R13 rts full", rts_out, 1);
        read_buf();
        chk("R8 full cleared", rx_full, 0);
        chk("R13 rts empty", rts_out, 0);

        // R3 7-bit MSB-first
        cfg_len = 2'd0; cfg_msb_first = 1'b1;
        send_frame(9'h05A, 0, 0, 0);
        exp_irq++;
        check_char("R3 msb 7bit", 9'h05A, 0, 0, 0, exp_irq);
        read_buf();

        // R4 9-bit even parity, wrong parity
        cfg_len = 2'd2; cfg_msb_first = 1'b0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_frame(9'h1C3, 1, 0, 0);
        exp_irq++;
        check_char("R4 bad even", 9'h1C3, 0, 1, 0, exp_irq);
        read_buf();
        chk("R8 parity cleared", err_parity, 0);

        // R4 odd parity, correct
        cfg_par_odd = 1'b1;
        send_frame(9'h0F0, 0, 0, 0);
        exp_irq++;
        check_char("R4 good odd", 9'h0F0, 0, 0, 0, exp_irq);
        read_buf();

        // R5 two stops, second low
        cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_two_stop = 1'b1;
        send_frame(9'h066, 0, 1, 0);
        exp_irq++;
        check_char("R5 stop2 low", 9'h066, 1, 0, 0, exp_irq);
        read_buf();
        chk("R8 frame cleared", err_frame, 0);
        cfg_two_stop = 1'b0;

        // R10 data inversion, R11 with pin inversion
        cfg_data_inv = 1'b1;
        send_frame(9'h03C, 0, 0, 0);
        exp_irq++;
        check_char("R10 data inv", 9'h03C, 0, 0, 0, exp_irq);
        read_buf();
        cfg_pin_inv = 1'b1;
        idle(8);
        send_frame(9'h0D2, 0, 0, 0);
        exp_irq++;
        check_char("R11 pin inv", 9'h0D2, 0, 0, 0, exp_irq);
        read_buf();
        cfg_data_inv = 1'b0; cfg_pin_inv = 1'b0;
        idle(8);

        // R6 overrun: two frames without a read
        send_frame(9'h011, 0, 0, 0);
        exp_irq++;
        chk("R6 no overrun yet", err_overrun, 0);
        send_frame(9'h022, 0, 0, 0);
        exp_irq++;
        chk("R6 overrun", err_overrun, 1);
        chk("R7 sum on overrun", err_sum, 1);
        chk("R6 irq", irq_cnt, exp_irq);
        read_buf();
        chk("R8 overrun cleared", err_overrun, 0);
        chk("R8 sum cleared", err_sum, 0);

        // R9 start glitch
        for (int i = 0; i < 4; i++) tick_once(1'b0);
        idle(40);
        chk("R9 glitch irq", irq_cnt, exp_irq);
        chk("R9 glitch full", rx_full, 0);

        // R12 short pulse at mid bit 0, filter off then on
        send_frame(9'h000, 0, 0, 1);
        exp_irq++;
        check_char("R12 unfiltered", 9'h001, 0, 0, 0, exp_irq);
        read_buf();
        cfg_filt_en = 1'b1;
        idle(8);
        send_frame(9'h000, 0, 0, 1);
        exp_irq++;
        check_char("R12 filtered", 9'h000, 0, 0, 0, exp_irq);
        read_buf();
        cfg_filt_en = 1'b0;

        // R14 disabled reception, R13 rts while disabled
        rx_en = 1'b0;
        @(negedge clk);
        chk("R13 rts disabled", rts_out, 1);
        send_frame(9'h055, 0, 0, 0);
        chk("R14 no irq", irq_cnt, exp_irq);
        chk("R14 no full", rx_full, 0);
        cfg_rts_en = 1'b0;
        @(negedge clk);
        chk("R13 rts off", rts_out, 0);
        rx_en = 1'b1; cfg_rts_en = 1'b1;
        idle(8);

        // Random frames
        for (int k = 0; k < 40; k++) begin
            cfg_len       = 2'($urandom_range(0, 2));
            cfg_par_en    = 1'($urandom_range(0, 1));
            cfg_par_odd   = 1'($urandom_range(0, 1));
            cfg_two_stop  = 1'($urandom_range(0, 1));
            cfg_msb_first = 1'($urandom_range(0, 1));
            cfg_data_inv  = 1'($urandom_range(0, 1));
            cfg_pin_inv   = 1'($urandom_range(0, 1));
            cfg_filt_en   = 1'($urandom_range(0, 1));
            idle(8);
            d  = 9'($urandom) & len_mask(cfg_len);
            bp = cfg_par_en && ($urandom_range(0, 3) == 0);
            bs = ($urandom_range(0, 3) == 0);
            send_frame(d, bp, bs, 0);
            exp_irq++;
            check_char("R2 random", d, bs, bp, 0, exp_irq);
            read_buf();
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule